// File: doc/BRIEF.md
# Flash Command Interface Controller

This block models the command decoder and write sequencer of a NOR flash device whose array is split into equal blocks, each with its own lock bit. A host writes commands over a simple address/data/write-strobe bus. Every cycle the block also returns read data for the current bus address. The command history decides whether that data comes from the array, from the identifier space or from the status register.

Altering operations are block erase, full-chip erase, word write and lock-bit set/clear. Each one is started by a setup command followed by a confirm or data cycle. Word writes and lock changes take a parameterised number of busy cycles. Erases step through the affected words one word per cycle, so a block erase can be suspended partway through. While an erase is suspended, the host may read other blocks and write words into them. While a word write is suspended, the host may only read. A digital write-voltage-low input stands in for the supply conditions and gates every altering operation. The array is a plain register memory that can be inferred as block RAM.

Top module: `flash_cmd_ctrl`

## Requirements
- R1: After reset the controller is idle and in array-read mode, so a bus read returns array contents rather than status.
- R2: An altering operation only starts after its two-cycle sequence. For a word write, command 0x40 is followed by a data cycle carrying the address and the value. The value is stored once the busy period ends, and later array reads return it.
- R3: If `wp_low` is high when a confirm or data cycle is processed, nothing is altered. Status bit 3 is set, together with bit 4 for a word write, bit 5 for an erase, or both for a lock change.
- R4: A block whose lock bit is set rejects block erase (status bits 5 and 1) and word write (bits 4 and 1), and full-chip erase (0x30 then 0xD0) leaves it intact. Lock set is 0x60 then 0x01, and lock clear is 0x60 then 0xD0, both at an address inside the block.
- R5: After 0xB0 during an erase, status reads 0xC0 (ready, erase-suspended). Reads and word writes to other blocks work. A word write to the suspended block is rejected with status bit 4. A later 0xD0 resumes the erase and completes it.
- R6: After 0xB0 during a word write, status reads 0x84 (ready, write-suspended). Array reads are allowed, but any other altering command is ignored. A later 0xD0 completes the write.
- R7: Status is the byte {ready, erase-suspended, erase error, write error, voltage low, write-suspended, lock error, 0} in the low bits, with the upper bits zero. After any setup command, and after an operation finishes, reads return status until 0xFF is written.
- R8: Command 0x90 selects identifier reads: offset 0 of any block gives the manufacturer code (0x5A), offset 1 gives the device code (0xC3), and offset 2 gives that block's lock bit. Identifier and status reads work while `wp_low` is high.
- R9: A setup command followed by a wrong confirm code aborts the operation. It sets status bits 5 and 4, leaves the controller in status-read mode, and leaves the array unchanged.
- R10: Command 0x50 clears status bits 5, 4, 3 and 1 without changing the read mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_we | input | 1 | Command write strobe, one cycle per bus write |
| bus_addr | input | ADDR_W | Word address for writes and reads |
| bus_wdata | input | DATA_W | Command or data value; commands use bits 7:0 |
| wp_low | input | 1 | Write voltage below lockout level |
| bus_rdata | output | DATA_W | Registered read data, valid one cycle after the address |

## Verification
The bench goes after these corner cases:
- A suspend arriving mid-erase. A design that ignored it would finish the erase and report busy or ready without bit 6. One that lost its erase pointer would leave words unerased after the resume.
- A nested word write to the block that is suspended. A design missing this check would corrupt a half-erased block.
- Locked blocks during a full-chip erase, and writes attempted with `wp_low` high, both of which must leave data untouched.
- Wrong confirm codes, which a weak decoder would run as an erase.
- A reset taken while in status mode, and status persisting after completion until 0xFF. Getting either wrong shows up as a status byte where array data belongs, or the reverse.

Random word writes to unlocked blocks, checked against a shadow array, cover the ordinary path.

// File: rtl/fcc_pkg.sv
package fcc_pkg;

  typedef enum logic [3:0] {
    S_IDLE, S_ERS_SET, S_CHIP_SET, S_WR_SET, S_LCK_SET,
    S_ERASE, S_WRITE, S_ESUSP, S_WSUSP
  } seq_st_t;

  typedef enum logic [1:0] {RM_ARRAY, RM_IDENT, RM_STATUS} rd_mode_t;

  localparam logic [7:0] CMD_READ   = 8'hFF;
  localparam logic [7:0] CMD_IDENT  = 8'h90;
  localparam logic [7:0] CMD_STAT   = 8'h70;
  localparam logic [7:0] CMD_CLR    = 8'h50;
  localparam logic [7:0] CMD_BERASE = 8'h20;
  localparam logic [7:0] CMD_CERASE = 8'h30;
  localparam logic [7:0] CMD_WRITE  = 8'h40;
  localparam logic [7:0] CMD_LOCK   = 8'h60;
  localparam logic [7:0] CMD_SUSP   = 8'hB0;
  localparam logic [7:0] CMD_CONF   = 8'hD0;
  localparam logic [7:0] CMD_LSET   = 8'h01;

  // status bit positions
  localparam int SB_RDY  = 7;
  localparam int SB_ESUS = 6;
  localparam int SB_EERR = 5;
  localparam int SB_WERR = 4;
  localparam int SB_VLOW = 3;
  localparam int SB_WSUS = 2;
  localparam int SB_LERR = 1;

endpackage

// File: rtl/fcc_array.sv
module fcc_array #(
  parameter int ADDR_W = 6,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              we,
  input  logic [ADDR_W-1:0] waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [ADDR_W-1:0] raddr,
  output logic [DATA_W-1:0] rdata
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  always_ff @(posedge clk) begin
    rdata <= mem[raddr];
  end
endmodule

// File: rtl/fcc_seq.sv
module fcc_seq
  import fcc_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int BLK_W  = 2,
  parameter int DATA_W = 16,
  parameter int WR_CYC = 12
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    cmd_we,
  input  logic [ADDR_W-1:0]       cmd_addr,
  input  logic [DATA_W-1:0]       cmd_data,
  input  logic                    vpp_low,
  output logic                    mem_we,
  output logic [ADDR_W-1:0]       mem_waddr,
  output logic [DATA_W-1:0]       mem_wdata,
  output rd_mode_t                rd_mode,
  output logic [7:0]              status,
  output logic [(1<<BLK_W)-1:0]   lock
);
  localparam int NBLK  = 1 << BLK_W;
  localparam int OFF_W = ADDR_W - BLK_W;
  localparam int CNT_W = $clog2(WR_CYC + 1);
  localparam logic [CNT_W-1:0] CNT_LOAD = CNT_W'(WR_CYC - 1);

  seq_st_t            st_q;
  rd_mode_t           mode_q;
  logic               cw_q;
  logic [ADDR_W-1:0]  ca_q;
  logic [DATA_W-1:0]  cd_q;
  logic [ADDR_W-1:0]  ptr_q, end_q, wa_q;
  logic [DATA_W-1:0]  wd_q;
  logic [CNT_W-1:0]   wcnt_q;
  logic               lck_op_q, lck_val_q, esus_bg_q;
  logic               e_err_q, w_err_q, v_err_q, l_err_q;
  logic [NBLK-1:0]    lock_q;

  logic [7:0]         code;
  logic [BLK_W-1:0]   cblk;
  logic [BLK_W-1:0]   pblk;
  logic [BLK_W-1:0]   wblk;
  seq_st_t            ret_st;
  logic               susp_cmd;

  assign code     = cd_q[7:0];
  assign cblk     = ca_q[ADDR_W-1 -: BLK_W];
  assign pblk     = ptr_q[ADDR_W-1 -: BLK_W];
  assign wblk     = mem_waddr[ADDR_W-1 -: BLK_W];
  assign ret_st   = esus_bg_q ? S_ESUSP : S_IDLE;
  assign susp_cmd = cw_q && (code == CMD_SUSP);

  // read-only commands common to idle and suspended states
  function automatic rd_mode_t mode_next(input logic [7:0] c, input rd_mode_t cur);
    case (c)
      CMD_READ:  mode_next = RM_ARRAY;
      CMD_IDENT: mode_next = RM_IDENT;
      CMD_STAT:  mode_next = RM_STATUS;
      default:   mode_next = cur;
    endcase
  endfunction

  // array write port: erase stepping or word-write completion
  always_comb begin
    mem_we    = 1'b0;
    mem_waddr = wa_q;
    mem_wdata = wd_q;
    if (st_q == S_ERASE) begin
      mem_waddr = ptr_q;
      mem_wdata = '1;
      mem_we    = !lock_q[pblk];
    end else if (st_q == S_WRITE && wcnt_q == '0 && !lck_op_q && !susp_cmd) begin
      mem_we = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q      <= S_IDLE;
      mode_q    <= RM_ARRAY;
      cw_q      <= 1'b0;
      ca_q      <= '0;
      cd_q      <= '0;
      ptr_q     <= '0;
      end_q     <= '0;
      wa_q      <= '0;
      wd_q      <= '0;
      wcnt_q    <= '0;
      lck_op_q  <= 1'b0;
      lck_val_q <= 1'b0;
      esus_bg_q <= 1'b0;
      e_err_q   <= 1'b0;
      w_err_q   <= 1'b0;
      v_err_q   <= 1'b0;
      l_err_q   <= 1'b0;
      lock_q    <= '0;
    end else begin
      cw_q <= cmd_we;
      ca_q <= cmd_addr;
      cd_q <= cmd_data;
      case (st_q)
        S_IDLE: if (cw_q) begin
          mode_q <= mode_next(code, mode_q);
          case (code)
            CMD_CLR: begin
              e_err_q <= 1'b0; w_err_q <= 1'b0; v_err_q <= 1'b0; l_err_q <= 1'b0;
            end
            CMD_BERASE: begin st_q <= S_ERS_SET;  mode_q <= RM_STATUS; end
            CMD_CERASE: begin st_q <= S_CHIP_SET; mode_q <= RM_STATUS; end
            CMD_WRITE:  begin st_q <= S_WR_SET;   mode_q <= RM_STATUS; end
            CMD_LOCK:   begin st_q <= S_LCK_SET;  mode_q <= RM_STATUS; end
            default: ;
          endcase
        end
        S_ERS_SET: if (cw_q) begin
          mode_q <= RM_STATUS;
          st_q   <= S_IDLE;
          if (code != CMD_CONF) begin
            e_err_q <= 1'b1; w_err_q <= 1'b1;
          end else if (vpp_low) begin
            e_err_q <= 1'b1; v_err_q <= 1'b1;
          end else if (lock_q[cblk]) begin
            e_err_q <= 1'b1; l_err_q <= 1'b1;
          end else begin
            ptr_q <= {cblk, {OFF_W{1'b0}}};
            end_q <= {cblk, {OFF_W{1'b1}}};
            st_q  <= S_ERASE;
          end
        end
        S_CHIP_SET: if (cw_q) begin
          mode_q <= RM_STATUS;
          st_q   <= S_IDLE;
          if (code != CMD_CONF) begin
            e_err_q <= 1'b1; w_err_q <= 1'b1;
          end else if (vpp_low) begin
            e_err_q <= 1'b1; v_err_q <= 1'b1;
          end else begin
            ptr_q <= '0;
            end_q <= '1;
            st_q  <= S_ERASE;
          end
        end
        S_LCK_SET: if (cw_q) begin
          mode_q <= RM_STATUS;
          st_q   <= S_IDLE;
          if (code != CMD_CONF && code != CMD_LSET) begin
            e_err_q <= 1'b1; w_err_q <= 1'b1;
          end else if (vpp_low) begin
            e_err_q <= 1'b1; w_err_q <= 1'b1; v_err_q <= 1'b1;
          end else begin
            lck_op_q  <= 1'b1;
            lck_val_q <= (code == CMD_LSET);
            wa_q      <= ca_q;
            wcnt_q    <= CNT_LOAD;
            st_q      <= S_WRITE;
          end
        end
        S_WR_SET: if (cw_q) begin
          mode_q <= RM_STATUS;
          st_q   <= ret_st;
          if (vpp_low) begin
            w_err_q <= 1'b1; v_err_q <= 1'b1;
          end else if (lock_q[cblk]) begin
            w_err_q <= 1'b1; l_err_q <= 1'b1;
          end else if (esus_bg_q && cblk == pblk) begin
            w_err_q <= 1'b1;
          end else begin
            lck_op_q <= 1'b0;
            wa_q     <= ca_q;
            wd_q     <= cd_q;
            wcnt_q   <= CNT_LOAD;
            st_q     <= S_WRITE;
          end
          if (!(!vpp_low && !lock_q[cblk] && !(esus_bg_q && cblk == pblk)))
            esus_bg_q <= 1'b0;
        end
        S_ERASE: begin
          if (susp_cmd) begin
            st_q   <= S_ESUSP;
            mode_q <= RM_STATUS;
          end else if (ptr_q == end_q) begin
            st_q <= S_IDLE;
          end else begin
            ptr_q <= ptr_q + 1'b1;
          end
        end
        S_ESUSP: if (cw_q) begin
          mode_q <= mode_next(code, mode_q);
          case (code)
            CMD_CLR: begin
              e_err_q <= 1'b0; w_err_q <= 1'b0; v_err_q <= 1'b0; l_err_q <= 1'b0;
            end
            CMD_WRITE: begin
              st_q      <= S_WR_SET;
              esus_bg_q <= 1'b1;
              mode_q    <= RM_STATUS;
            end
            CMD_CONF: begin
              st_q   <= S_ERASE;
              mode_q <= RM_STATUS;
            end
            default: ;
          endcase
        end
        S_WRITE: begin
          if (susp_cmd && !lck_op_q) begin
            st_q   <= S_WSUSP;
            mode_q <= RM_STATUS;
          end else if (wcnt_q == '0) begin
            if (lck_op_q) lock_q[wa_q[ADDR_W-1 -: BLK_W]] <= lck_val_q;
            st_q      <= ret_st;
            esus_bg_q <= 1'b0;
          end else begin
            wcnt_q <= wcnt_q - 1'b1;
          end
        end
        S_WSUSP: if (cw_q) begin
          mode_q <= mode_next(code, mode_q);
          if (code == CMD_CONF) begin
            st_q   <= S_WRITE;
            mode_q <= RM_STATUS;
          end
        end
        default: st_q <= S_IDLE;
      endcase
    end
  end

  assign rd_mode = mode_q;
  assign lock    = lock_q;
  always_comb begin
    status          = '0;
    status[SB_RDY]  = (st_q != S_ERASE) && (st_q != S_WRITE);
    status[SB_ESUS] = (st_q == S_ESUSP) || esus_bg_q;
    status[SB_EERR] = e_err_q;
    status[SB_WERR] = w_err_q;
    status[SB_VLOW] = v_err_q;
    status[SB_WSUS] = (st_q == S_WSUSP);
    status[SB_LERR] = l_err_q;
  end

  // R1
  reset_mode_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> (st_q == S_IDLE && mode_q == RM_ARRAY));

  // R4
  lock_gate_chk: assert property (@(posedge clk) disable iff (rst)
    mem_we |-> !lock_q[wblk]);

  // R3
  lockout_chk: assert property (@(posedge clk) disable iff (rst)
    (cw_q && vpp_low && (st_q == S_ERS_SET || st_q == S_CHIP_SET || st_q == S_WR_SET))
      |=> (st_q != S_ERASE && st_q != S_WRITE && status[SB_VLOW]));

  // R9
  bad_confirm_chk: assert property (@(posedge clk) disable iff (rst)
    (cw_q && st_q == S_ERS_SET && code != CMD_CONF)
      |=> (status[SB_EERR] && status[SB_WERR] && mode_q == RM_STATUS && st_q == S_IDLE));

  // R5
  esus_region_chk: assert property (@(posedge clk) disable iff (rst)
    (mem_we && esus_bg_q) |-> (wblk != pblk));

  // R6
  wsus_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (st_q == S_WSUSP) |-> !mem_we);
endmodule

// File: rtl/fcc_rdout.sv
module fcc_rdout
  import fcc_pkg::*;
#(
  parameter int         BLK_W  = 2,
  parameter int         DATA_W = 16,
  parameter logic [7:0] MFR_ID = 8'h5A,
  parameter logic [7:0] DEV_ID = 8'hC3
) (
  input  logic                  clk,
  input  logic                  rst,
  input  rd_mode_t              rd_mode,
  input  logic [1:0]            sel,
  input  logic [BLK_W-1:0]      blk,
  input  logic [7:0]            status,
  input  logic [(1<<BLK_W)-1:0] lock,
  input  logic [DATA_W-1:0]     mem_q,
  output logic [DATA_W-1:0]     rdata
);
  localparam int PAD = DATA_W - 8;

  rd_mode_t          mode_d;
  logic [DATA_W-1:0] aux_d;
  logic [7:0]        id_byte;

  always_comb begin
    case (sel)
      2'd0:    id_byte = MFR_ID;
      2'd1:    id_byte = DEV_ID;
      2'd2:    id_byte = {7'd0, lock[blk]};
      default: id_byte = 8'd0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_d <= RM_ARRAY;
      aux_d  <= '0;
    end else begin
      mode_d <= rd_mode;
      aux_d  <= {{PAD{1'b0}}, (rd_mode == RM_STATUS) ? status : id_byte};
    end
  end

  assign rdata = (mode_d == RM_ARRAY) ? mem_q : aux_d;
endmodule

// File: rtl/flash_cmd_ctrl.sv
module flash_cmd_ctrl
  import fcc_pkg::*;
#(
  parameter int         ADDR_W = 6,
  parameter int         BLK_W  = 2,
  parameter int         DATA_W = 16,
  parameter int         WR_CYC = 12,
  parameter logic [7:0] MFR_ID = 8'h5A,
  parameter logic [7:0] DEV_ID = 8'hC3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  input  logic              wp_low,
  output logic [DATA_W-1:0] bus_rdata
);
  localparam int NBLK = 1 << BLK_W;

  logic              mem_we;
  logic [ADDR_W-1:0] mem_waddr;
  logic [DATA_W-1:0] mem_wdata;
  logic [DATA_W-1:0] mem_q;
  rd_mode_t          rd_mode;
  logic [7:0]        status;
  logic [NBLK-1:0]   lock;

  fcc_seq #(.ADDR_W(ADDR_W), .BLK_W(BLK_W), .DATA_W(DATA_W), .WR_CYC(WR_CYC)) u_seq (
    .clk(clk), .rst(rst), .cmd_we(bus_we), .cmd_addr(bus_addr), .cmd_data(bus_wdata),
    .vpp_low(wp_low), .mem_we(mem_we), .mem_waddr(mem_waddr), .mem_wdata(mem_wdata),
    .rd_mode(rd_mode), .status(status), .lock(lock)
  );

  fcc_array #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_arr (
    .clk(clk), .we(mem_we), .waddr(mem_waddr), .wdata(mem_wdata),
    .raddr(bus_addr), .rdata(mem_q)
  );

  fcc_rdout #(.BLK_W(BLK_W), .DATA_W(DATA_W), .MFR_ID(MFR_ID), .DEV_ID(DEV_ID)) u_out (
    .clk(clk), .rst(rst), .rd_mode(rd_mode), .sel(bus_addr[1:0]),
    .blk(bus_addr[ADDR_W-1 -: BLK_W]), .status(status), .lock(lock),
    .mem_q(mem_q), .rdata(bus_rdata)
  );
endmodule

// File: tb/sim_flash_cmd_ctrl.sv
module sim_flash_cmd_ctrl;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bus_we = 1'b0;
  logic [5:0]  bus_addr = '0;
  logic [15:0] bus_wdata = '0;
  logic        wp_low = 1'b0;
  logic [15:0] bus_rdata;

  int vecs = 0;
  int fails = 0;
  logic [15:0] sh [64];

  always #4 clk = ~clk;

  flash_cmd_ctrl u0 (
    .clk(clk), .rst(rst), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .wp_low(wp_low), .bus_rdata(bus_rdata)
  );

  function automatic logic [15:0] sr(input bit rdy, input bit es, input bit ee,
                                     input bit we, input bit vl, input bit ws, input bit le);
    return {8'h00, rdy, es, ee, we, vl, ws, le, 1'b0};
  endfunction

  task automatic chk(input string tag, input logic [15:0] got, input logic [15:0] exp);
    vecs++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s got=%h exp=%h", tag, got, exp);
    end
  endtask

  task automatic wr(input logic [5:0] a, input logic [15:0] d);
    @(negedge clk);
    bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_we = 1'b0;
    @(negedge clk);
  endtask

  task automatic rd(input logic [5:0] a, output logic [15:0] d);
    bus_addr = a;
    @(negedge clk);
    d = bus_rdata;
  endtask

  task automatic poll(output logic [15:0] s);
    int n = 0;
    rd(6'd0, s);
    while (!s[7] && n < 300) begin
      rd(6'd0, s);
      n++;
    end
  endtask

  initial begin
    logic [15:0] v;
    repeat (4) @(negedge clk);
    rst = 1'b0;

    // chip erase to give the array known contents
    wr(0, 16'h0030); wr(0, 16'h00D0); poll(v);
    chk("R7 status after chip erase", v, sr(1,0,0,0,0,0,0));
    wr(0, 16'h00FF);
    rd(6'd5, v);  chk("R2 erased word", v, 16'hFFFF);
    rd(6'd63, v); chk("R2 erased last word", v, 16'hFFFF);

    // reset taken while in status mode
    wr(0, 16'h0070);
    @(negedge clk); rst = 1'b1; @(negedge clk); @(negedge clk); rst = 1'b0;
    rd(6'd5, v); chk("R1 array mode after reset", v, 16'hFFFF);

    // identifier space
    wr(0, 16'h0090);
    rd(6'd0, v);  chk("R8 manufacturer code", v, 16'h005A);
    rd(6'd1, v);  chk("R8 device code", v, 16'h00C3);
    rd(6'd18, v); chk("R8 lock bit clear", v, 16'h0000);

    // word write and status persistence
    wr(0, 16'h0040); wr(6'd3, 16'hA5C3); poll(v);
    chk("R2 write done", v, sr(1,0,0,0,0,0,0));
    rd(6'd3, v); chk("R7 status persists", v, sr(1,0,0,0,0,0,0));
    wr(0, 16'h00FF);
    rd(6'd3, v); chk("R2 written value", v, 16'hA5C3);

    // wrong confirm
    wr(0, 16'h0020); wr(0, 16'h0055);
    rd(6'd3, v); chk("R9 bad confirm status", v, sr(1,0,1,1,0,0,0));
    wr(0, 16'h00FF);
    rd(6'd3, v); chk("R9 array untouched", v, 16'hA5C3);
    wr(0, 16'h0050); wr(0, 16'h0070);
    rd(6'd0, v); chk("R10 clear status", v, sr(1,0,0,0,0,0,0));

    // write-voltage lockout
    wp_low = 1'b1;
    wr(0, 16'h0040); wr(6'd7, 16'h1111);
    rd(6'd0, v); chk("R3 write under lockout", v, sr(1,0,0,1,1,0,0));
    wr(0, 16'h0090);
    rd(6'd0, v); chk("R8 ident under lockout", v, 16'h005A);
    wr(0, 16'h0020); wr(6'd0, 16'h00D0);
    rd(6'd0, v); chk("R3 erase under lockout", v, sr(1,0,1,1,1,0,0));
    wp_low = 1'b0;
    wr(0, 16'h00FF);
    rd(6'd7, v); chk("R3 word unchanged", v, 16'hFFFF);
    rd(6'd3, v); chk("R3 block not erased", v, 16'hA5C3);
    wr(0, 16'h0050);

    // lock bits
    wr(0, 16'h0040); wr(6'd20, 16'h1357); poll(v);
    wr(0, 16'h0040); wr(6'd50, 16'h2468); poll(v);
    wr(0, 16'h0060); wr(6'd16, 16'h0001); poll(v);
    chk("R4 lock set done", v, sr(1,0,0,0,0,0,0));
    wr(0, 16'h0090);
    rd(6'd18, v); chk("R4 R8 lock bit readable", v, 16'h0001);
    wr(0, 16'h0020); wr(6'd16, 16'h00D0);
    rd(6'd0, v); chk("R4 erase locked block", v, sr(1,0,1,0,0,0,1));
    wr(0, 16'h0050);
    wr(0, 16'h0040); wr(6'd21, 16'hBEEF);
    rd(6'd0, v); chk("R4 write locked block", v, sr(1,0,0,1,0,0,1));
    wr(0, 16'h0050);
    wr(0, 16'h0030); wr(0, 16'h00D0); poll(v);
    wr(0, 16'h00FF);
    rd(6'd20, v); chk("R4 locked block survives chip erase", v, 16'h1357);
    rd(6'd21, v); chk("R4 locked write ignored", v, 16'hFFFF);
    rd(6'd50, v); chk("R4 unlocked block erased", v, 16'hFFFF);
    rd(6'd3, v);  chk("R4 block0 erased", v, 16'hFFFF);
    wr(0, 16'h0060); wr(6'd17, 16'h00D0); poll(v);
    wr(0, 16'h0090);
    rd(6'd18, v); chk("R4 lock cleared", v, 16'h0000);

    // erase suspend
    wr(0, 16'h0040); wr(6'd33, 16'h0F0F); poll(v);
    wr(0, 16'h0020); wr(6'd32, 16'h00D0); wr(0, 16'h00B0);
    rd(6'd0, v); chk("R5 erase suspended", v, sr(1,1,0,0,0,0,0));
    wr(0, 16'h00FF);
    rd(6'd20, v); chk("R5 read other block", v, 16'h1357);
    wr(0, 16'h0040); wr(6'd5, 16'h7777); poll(v);
    chk("R5 nested write done", v, sr(1,1,0,0,0,0,0));
    wr(0, 16'h0040); wr(6'd40, 16'h1234);
    rd(6'd0, v); chk("R5 write to suspended block", v, sr(1,1,0,1,0,0,0));
    wr(0, 16'h0050); wr(0, 16'h0070);
    rd(6'd0, v); chk("R10 clear in suspend", v, sr(1,1,0,0,0,0,0));
    wr(0, 16'h00D0); poll(v);
    chk("R5 resumed erase done", v, sr(1,0,0,0,0,0,0));
    wr(0, 16'h00FF);
    rd(6'd33, v); chk("R5 block erased", v, 16'hFFFF);
    rd(6'd40, v); chk("R5 rejected word", v, 16'hFFFF);
    rd(6'd5, v);  chk("R5 nested word", v, 16'h7777);

    // write suspend
    wr(0, 16'h0040); wr(6'd9, 16'hABCD); wr(0, 16'h00B0);
    rd(6'd0, v); chk("R6 write suspended", v, sr(1,0,0,0,0,1,0));
    wr(0, 16'h0040); wr(6'd10, 16'h5555);
    rd(6'd0, v); chk("R6 write ignored in suspend", v, sr(1,0,0,0,0,1,0));
    wr(0, 16'h00FF);
    rd(6'd5, v);  chk("R6 read other word", v, 16'h7777);
    wr(0, 16'h00D0); poll(v);
    chk("R6 resumed write done", v, sr(1,0,0,0,0,0,0));
    wr(0, 16'h00FF);
    rd(6'd9, v);  chk("R6 written word", v, 16'hABCD);
    rd(6'd10, v); chk("R6 ignored word", v, 16'hFFFF);

    // random word writes against a shadow array
    wr(0, 16'h0030); wr(0, 16'h00D0); poll(v);
    for (int i = 0; i < 64; i++) sh[i] = 16'hFFFF;
    void'($urandom(32'd20240611));
    for (int i = 0; i < 30; i++) begin
      logic [5:0]  a;
      logic [15:0] d;
      a = 6'($urandom % 64);
      d = 16'($urandom);
      wr(0, 16'h0040); wr(a, d); poll(v);
      sh[a] = d;
      wr(0, 16'h00FF);
      a = 6'($urandom % 64);
      rd(a, v); chk("R2 random readback", v, sh[a]);
    end

    $display("== %0d vectors applied, %0d miscompares ==", vecs, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired got=hung exp=done");
    $display("== %0d vectors applied, %0d miscompares ==", vecs, fails);
    $finish;
  end
endmodule